// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This block is a one-stage execution unit for packed integer data. Each cycle it may accept two 64-bit operands, a 4-bit operation code and a 2-bit element-size select. It splits the operands into independent lanes of 8, 16 or 32 bits and applies one operation to every lane. It returns the 64-bit result one clock later, marked by a valid strobe.

Arithmetic can add or subtract with wraparound, with signed saturation or with unsigned saturation. Compares turn each lane into an all-ones or all-zeros mask. Four bitwise operations work on the whole 64-bit word. The unit keeps no flags. Its only side indication is an illegal-operation strobe, which marks requests that have no defined packed meaning.

Top module: `simd_int_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `result` and `illegal_op` are updated on that same edge. A synchronous reset drives `out_valid`, `result` and `illegal_op` to 0.
- R2: `size` 0 selects eight 8-bit lanes, 1 selects four 16-bit lanes, and 2 or 3 select two 32-bit lanes. No carry or borrow passes from one lane into the next.
- R3: Opcode 0 (add) and opcode 3 (subtract) keep the low N bits of each lane's true sum or difference.
- R4: Opcode 2 (add) and opcode 5 (subtract) clamp each byte or word lane to the unsigned range, which is 0 to 255 for bytes and 0 to 65535 for words.
- R5: Opcode 1 (add) and opcode 4 (subtract) clamp each byte or word lane to the signed range, which is -128 to 127 for bytes and -32768 to 32767 for words.
- R6: Opcode 6 writes all ones to each lane where the two operands are equal. Opcode 7 writes all ones to each lane where `a` is greater than `b` as signed values. Every other lane receives all zeros.
- R7: A saturating opcode (1, 2, 4 or 5) combined with `size` 2 or 3 sets `illegal_op` to 1 and returns the wraparound result of the same add or subtract.
- R8: Opcodes 8, 9, 10 and 11 compute `a & b`, `~a & b`, `a | b` and `a ^ b` across all 64 bits, whatever the value of `size`.
- R9: Opcodes 12 to 15 are undefined. They return a zero result with `illegal_op` set to 1.
- R10: A legal request returns `illegal_op` = 0. While `in_valid` is low, `result` and `illegal_op` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| size | input | 2 | Lane width select |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered result |
| illegal_op | output | 1 | Registered illegal-request indication |

## Verification
The unit holds only one stage of state, so any fault in a lane, the size selection or the decode shows up at the ports on the very edge after the request. A broken lane boundary appears as a corrupted neighbouring lane in the same result word. A wrong saturation decision appears as a wrapped value where a clamped one was due. A stale output register appears as an output that changes while the unit is idle, one cycle after `in_valid` falls.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   localparam int BYTE_W  = 8;
   localparam int WORD_W  = 16;
   localparam int DWORD_W = 32;

   typedef enum logic [3:0] {
      OP_ADD_WRAP  = 4'd0,
      OP_ADD_SSAT  = 4'd1,
      OP_ADD_USAT  = 4'd2,
      OP_SUB_WRAP  = 4'd3,
      OP_SUB_SSAT  = 4'd4,
      OP_SUB_USAT  = 4'd5,
      OP_CMP_EQ    = 4'd6,
      OP_CMP_GT    = 4'd7,
      OP_BIT_AND   = 4'd8,
      OP_BIT_ANDN  = 4'd9,
      OP_BIT_OR    = 4'd10,
      OP_BIT_XOR   = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      SAT_NONE     = 2'd0,
      SAT_SIGNED   = 2'd1,
      SAT_UNSIGNED = 2'd2
   } sat_e;

   typedef enum logic [1:0] {
      KIND_ARITH = 2'd0,
      KIND_CMP   = 2'd1,
      KIND_LOGIC = 2'd2,
      KIND_UNDEF = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      LOP_AND  = 2'd0,
      LOP_ANDN = 2'd1,
      LOP_OR   = 2'd2,
      LOP_XOR  = 2'd3
   } lop_e;

   typedef struct packed {
      kind_e kind;
      logic  sub;
      sat_e  sat;
      logic  cmp_gt;
      lop_e  lop;
   } alu_ctl_t;

   function automatic alu_ctl_t decode_op(input logic [3:0] code);
      alu_ctl_t c;
      c.kind   = KIND_UNDEF;
      c.sub    = 1'b0;
      c.sat    = SAT_NONE;
      c.cmp_gt = 1'b0;
      c.lop    = LOP_AND;
      case (code)
         OP_ADD_WRAP: c.kind = KIND_ARITH;
         OP_ADD_SSAT: begin c.kind = KIND_ARITH; c.sat = SAT_SIGNED; end
         OP_ADD_USAT: begin c.kind = KIND_ARITH; c.sat = SAT_UNSIGNED; end
         OP_SUB_WRAP: begin c.kind = KIND_ARITH; c.sub = 1'b1; end
         OP_SUB_SSAT: begin c.kind = KIND_ARITH; c.sub = 1'b1; c.sat = SAT_SIGNED; end
         OP_SUB_USAT: begin c.kind = KIND_ARITH; c.sub = 1'b1; c.sat = SAT_UNSIGNED; end
         OP_CMP_EQ:   c.kind = KIND_CMP;
         OP_CMP_GT:   begin c.kind = KIND_CMP; c.cmp_gt = 1'b1; end
         OP_BIT_AND:  begin c.kind = KIND_LOGIC; c.lop = LOP_AND; end
         OP_BIT_ANDN: begin c.kind = KIND_LOGIC; c.lop = LOP_ANDN; end
         OP_BIT_OR:   begin c.kind = KIND_LOGIC; c.lop = LOP_OR; end
         OP_BIT_XOR:  begin c.kind = KIND_LOGIC; c.lop = LOP_XOR; end
         default:     c.kind = KIND_UNDEF;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_alu_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [LANE_W-1:0] op_a,
   input  logic [LANE_W-1:0] op_b,
   input  logic              sub,
   input  sat_e              sat,
   output logic [LANE_W-1:0] arith,
   output logic              eq,
   output logic              gt
);

   localparam int MSB = LANE_W - 1;
   localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] UMIN = '0;
   localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

   if (LANE_W < 2) begin : g_bad_width
      $error("simd_lane_unit: LANE_W must be at least 2");
   end

   logic [LANE_W:0]   ext;
   logic [LANE_W-1:0] wrap;
   logic              carry_out;
   logic              s_ovf;

   always_comb begin
      if (sub) ext = {1'b0, op_a} - {1'b0, op_b};
      else     ext = {1'b0, op_a} + {1'b0, op_b};
   end

   assign wrap      = ext[LANE_W-1:0];
   assign carry_out = ext[LANE_W];

   always_comb begin
      if (sub) s_ovf = (op_a[MSB] != op_b[MSB]) && (wrap[MSB] != op_a[MSB]);
      else     s_ovf = (op_a[MSB] == op_b[MSB]) && (wrap[MSB] != op_a[MSB]);
   end

   assign eq = (op_a == op_b);
   assign gt = ($signed(op_a) > $signed(op_b));

   if (SAT_EN) begin : g_sat
      always_comb begin
         arith = wrap;
         case (sat)
            SAT_UNSIGNED: if (carry_out) arith = sub ? UMIN : UMAX;
            SAT_SIGNED:   if (s_ovf)     arith = op_a[MSB] ? SMIN : SMAX;
            default:      arith = wrap;
         endcase
      end

      always_comb begin
         if (sat == SAT_UNSIGNED && !sub)
            AST_USAT_ADD_NOWRAP: assert (arith >= op_a); // R4
         if (sat == SAT_UNSIGNED && sub)
            AST_USAT_SUB_NOWRAP: assert (arith <= op_a); // R4
         if (sat == SAT_SIGNED && !sub && !op_a[MSB] && !op_b[MSB])
            AST_SSAT_POS_STAYS_POS: assert (!arith[MSB]); // R5
         if (sat == SAT_SIGNED && !sub && op_a[MSB] && op_b[MSB])
            AST_SSAT_NEG_STAYS_NEG: assert (arith[MSB]); // R5
      end
   end else begin : g_wrap_only
      logic [1:0] unused_sat;
      logic       unused_flags;
      assign unused_sat   = sat;
      assign unused_flags = carry_out ^ s_ovf;
      assign arith        = wrap;
   end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              sub,
   input  sat_e              sat,
   input  logic              cmp_gt,
   output logic [DATA_W-1:0] arith,
   output logic [DATA_W-1:0] mask
);

   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("simd_lane_array: DATA_W must be a multiple of LANE_W");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic eq_l;
      logic gt_l;

      simd_lane_unit #(
         .LANE_W (LANE_W),
         .SAT_EN (SAT_EN)
      ) u_lane (
         .op_a  (op_a[i*LANE_W +: LANE_W]),
         .op_b  (op_b[i*LANE_W +: LANE_W]),
         .sub   (sub),
         .sat   (sat),
         .arith (arith[i*LANE_W +: LANE_W]),
         .eq    (eq_l),
         .gt    (gt_l)
      );

      assign mask[i*LANE_W +: LANE_W] = {LANE_W{cmp_gt ? gt_l : eq_l}};
   end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  lop_e              lop,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      case (lop)
         LOP_AND:  res = op_a & op_b;
         LOP_ANDN: res = ~op_a & op_b;
         LOP_OR:   res = op_a | op_b;
         default:  res = op_a ^ op_b;
      endcase
   end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [3:0]        opcode,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal_op
);

   if (DATA_W % DWORD_W != 0 || DATA_W < DWORD_W) begin : g_bad_data_w
      $error("simd_int_alu: DATA_W must be a positive multiple of 32");
   end

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] arith_b, arith_w, arith_d;
   logic [DATA_W-1:0] mask_b, mask_w, mask_d;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] arith_sel, mask_sel;
   logic [DATA_W-1:0] next_res;
   logic              next_ill;
   logic              wide_lane;

   assign ctl       = decode_op(opcode);
   assign wide_lane = size[1];

   simd_lane_array #(.DATA_W(DATA_W), .LANE_W(BYTE_W), .SAT_EN(1'b1)) u_bytes (
      .op_a (a), .op_b (b), .sub (ctl.sub), .sat (ctl.sat),
      .cmp_gt (ctl.cmp_gt), .arith (arith_b), .mask (mask_b)
   );

   simd_lane_array #(.DATA_W(DATA_W), .LANE_W(WORD_W), .SAT_EN(1'b1)) u_words (
      .op_a (a), .op_b (b), .sub (ctl.sub), .sat (ctl.sat),
      .cmp_gt (ctl.cmp_gt), .arith (arith_w), .mask (mask_w)
   );

   simd_lane_array #(.DATA_W(DATA_W), .LANE_W(DWORD_W), .SAT_EN(1'b0)) u_dwords (
      .op_a (a), .op_b (b), .sub (ctl.sub), .sat (ctl.sat),
      .cmp_gt (ctl.cmp_gt), .arith (arith_d), .mask (mask_d)
   );

   simd_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op_a (a), .op_b (b), .lop (ctl.lop), .res (logic_res)
   );

   always_comb begin
      case (size)
         2'd0:    begin arith_sel = arith_b; mask_sel = mask_b; end
         2'd1:    begin arith_sel = arith_w; mask_sel = mask_w; end
         default: begin arith_sel = arith_d; mask_sel = mask_d; end
      endcase
   end

   always_comb begin
      next_ill = 1'b0;
      case (ctl.kind)
         KIND_ARITH: begin
            next_res = arith_sel;
            next_ill = (ctl.sat != SAT_NONE) && wide_lane;
         end
         KIND_CMP:   next_res = mask_sel;
         KIND_LOGIC: next_res = logic_res;
         default: begin
            next_res = '0;
            next_ill = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         result     <= '0;
         illegal_op <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result     <= next_res;
            illegal_op <= next_ill;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R1
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(illegal_op))); // R10
   AST_WIDE_SAT_FLAG: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size[1] && (opcode inside {4'd1, 4'd2, 4'd4, 4'd5})) |=> illegal_op); // R7
   AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode >= 4'd12) |=> (illegal_op && result == '0)); // R9
   AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode <= 4'd11 && !(size[1] && (opcode inside {4'd1, 4'd2, 4'd4, 4'd5})))
      |=> !illegal_op); // R10

endmodule

// File: tb/simd_int_alu_tb.sv
module simd_int_alu_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  op;
      logic [1:0]  sz;
      logic [63:0] va;
      logic [63:0] vb;
      logic [63:0] exp;
      logic        ill;
      int          req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      // R3 / R2: byte add, wraps per lane
      '{4'd0, 2'd0, 64'h80FF_0102_7F10_FF01, 64'h8001_0304_0110_0101, 64'h0000_0406_8020_0002, 1'b0, 3},
      // R2: same operands, word lanes
      '{4'd0, 2'd1, 64'h80FF_0102_7F10_FF01, 64'h8001_0304_0110_0101, 64'h0100_0406_8020_0002, 1'b0, 2},
      // R2: same operands, dword lanes
      '{4'd0, 2'd2, 64'h80FF_0102_7F10_FF01, 64'h8001_0304_0110_0101, 64'h0100_0406_8021_0002, 1'b0, 2},
      // R3: byte subtract, borrow stays in lane 0
      '{4'd3, 2'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_00FF, 1'b0, 3},
      // R4: unsigned saturating byte add
      '{4'd2, 2'd0, 64'hFF80_0102_9A00_0000, 64'h0180_0304_CD00_0000, 64'hFFFF_0406_FF00_0000, 1'b0, 4},
      // R4: unsigned saturating word subtract
      '{4'd5, 2'd1, 64'h0005_1000_FFFF_0000, 64'h0006_0FFF_0001_0000, 64'h0000_0001_FFFE_0000, 1'b0, 4},
      // R5: signed saturating byte add
      '{4'd1, 2'd0, 64'h7F80_4040_C0C0_0102, 64'h0180_4040_C0C0_FFFE, 64'h7F80_7F7F_8080_0000, 1'b0, 5},
      // R5: signed saturating word subtract
      '{4'd4, 2'd1, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_0001, 64'h8000_7FFF_FFFE_FFFE, 1'b0, 5},
      // R6: byte equality mask
      '{4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 1'b0, 6},
      // R6: signed word greater-than
      '{4'd7, 2'd1, 64'h0001_FFFF_8000_7FFF, 64'h0000_0000_7FFF_7FFF, 64'hFFFF_0000_0000_0000, 1'b0, 6},
      // R6: signed dword greater-than
      '{4'd7, 2'd2, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFE_0000_0003, 64'hFFFF_FFFF_0000_0000, 1'b0, 6},
      // R8: AND
      '{4'd8, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000, 1'b0, 8},
      // R8: AND-NOT
      '{4'd9, 2'd1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0F00_0F00_0F00_0F00, 1'b0, 8},
      // R8: OR
      '{4'd10, 2'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0, 1'b0, 8},
      // R8: XOR
      '{4'd11, 2'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 1'b0, 8},
      // R7: saturating add on dword lanes gives wrap plus flag
      '{4'd2, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0002, 1'b1, 7},
      // R7: saturating subtract with size 3
      '{4'd4, 2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, 1'b1, 7},
      // R9: undefined opcode
      '{4'd13, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0000, 1'b1, 9}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [3:0]  opcode;
   logic [1:0]  size;
   logic [63:0] a, b;
   logic        out_valid;
   logic [63:0] result;
   logic        illegal_op;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_int_alu u_dut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .opcode (opcode),
      .size (size), .a (a), .b (b), .out_valid (out_valid),
      .result (result), .illegal_op (illegal_op)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [3:0] op, input logic [1:0] sz,
                        input logic [63:0] va, input logic [63:0] vb);
      in_valid = v;
      opcode   = op;
      size     = sz;
      a        = va;
      b        = vb;
   endtask

   initial begin
      rst = 1'b1;
      drive(1'b0, 4'd0, 2'd0, '0, '0);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
      check("R1 result after reset", result, 64'd0);
      check("R1 illegal_op after reset", {63'd0, illegal_op}, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      // table, back to back
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].op, VECS[i].sz, VECS[i].va, VECS[i].vb);
         @(negedge clk);
         check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
         check($sformatf("R%0d vec %0d illegal_op", VECS[i].req, i),
               {63'd0, illegal_op}, {63'd0, VECS[i].ill});
         check("R1 out_valid during stream", {63'd0, out_valid}, 64'd1);
      end

      // R10: legal op after an illegal one clears the flag, then idle holds
      drive(1'b1, 4'd3, 2'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
      @(negedge clk);
      check("R3 word subtract wraps", result, 64'h0000_0000_0000_FFFF);
      check("R10 illegal_op clears on legal op", {63'd0, illegal_op}, 64'd0);
      drive(1'b0, 4'd13, 2'd2, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_1111_1111_1111);
      @(negedge clk);
      check("R1 out_valid drops when idle", {63'd0, out_valid}, 64'd0);
      check("R10 result holds when idle", result, 64'h0000_0000_0000_FFFF);
      check("R10 illegal_op holds when idle", {63'd0, illegal_op}, 64'd0);
      @(negedge clk);
      check("R10 result still held", result, 64'h0000_0000_0000_FFFF);

      // R2: dword lane boundary isolation on subtract
      drive(1'b1, 4'd3, 2'd2, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
      @(negedge clk);
      check("R2 dword borrow isolated", result, 64'h0000_0001_FFFF_FFFF);

      // R5: word add hits both limits exactly
      drive(1'b1, 4'd1, 2'd1, 64'h7FFF_8000_7FFE_8001, 64'h0000_0000_0001_FFFF);
      @(negedge clk);
      check("R5 signed word limits", result, 64'h7FFF_8000_7FFF_8000);

      // R1: reset while valid clears outputs
      drive(1'b1, 4'd11, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset overrides valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset clears result", result, 64'd0);
      rst = 1'b0;
      drive(1'b0, 4'd0, 2'd0, '0, '0);
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule